// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

The router takes 32 system interrupt lines and one timer line per processor, and drives a 16-bit priority-level vector to each of `NUM_CPU` processors. Each source line is level-sensitive. Its pending bit follows the line one clock later and clears when the line drops. A fixed table gives each source bit a priority level; sources whose level is 0 are dropped. Pending bits that are not masked are turned into levels, and those levels go only to one programmable target processor. Level-15 sources and each processor's own timer line reach their processors whatever the target. A single master-off bit in the mask register silences every output.

Software reaches the block through a 32-bit, word-only register port with a byte address. A small two-state machine handles the port. In `BUS_IDLE` the port is ready, and a valid request moves it to `BUS_RESP`. In `BUS_RESP` the response is presented for one cycle and the machine always returns to `BUS_IDLE`.

Top module: `irq_route_top`

## Requirements
- R1: After reset, pending reads 0, the target reads 0, the mask register reads 0 at byte 0x04, every output level is 0, and the internal mask holds 0x0FA2007F.
- R2: Pending bit b is 1 exactly when source line b was high at the previous clock edge and its table level is nonzero. Bits 23 to 26 and 31 are always 0. Byte 0x00 reads the pending word.
- R3: The level table is as follows. Bits 0 to 6 and 7 to 13 each give 2, 3, 5, 7, 9, 11, 13 in turn. Bits 14 and 15 give 12. Bits 16 to 22 give 6, 13, 4, 10, 8, 9, 11. Bits 27 to 30 give 15. Processor output bit k is set when a routed source has level k.
- R4: Writing byte 0x08 clears mask bits and writing byte 0x0C sets them. Both are limited to 0xF05DFF80, so bits outside it keep their reset value. Byte 0x04 reads the mask AND 0xF05DFF80.
- R5: Setting or clearing mask bits never changes the pending word.
- R6: Writing byte 0x10 sets the target to the low log2(NUM_CPU) bits of the data, and byte 0x10 reads it back. Only the target receives table levels, and only from unmasked pending bits.
- R7: While mask bit 31 is set, every processor's level vector is 0, including its level-15 and timer bits.
- R8: While any of source bits 27 to 30 is pending and bit 31 is clear, bit 15 is set for every processor, even when that source's own mask bit is set.
- R9: Timer line n, one clock after it is sampled high, sets bit 14 of processor n only. Mask bit 31 is the only mask that affects it.
- R10: One request is accepted per visit to `BUS_IDLE`. The response arrives in the following cycle, while ready is low. A request whose address has bits 1:0 nonzero changes nothing and reads 0. So do unused offsets.
- R11: Processor n's vector sits in `cpu_lvl_o[16n+15:16n]`, and its bits 1:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | System interrupt lines, level-sensitive |
| tmr_i | input | NUM_CPU | Per-processor timer lines |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register port ready (state `BUS_IDLE`) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid (state `BUS_RESP`) |
| rsp_rdata_o | output | 32 | Read data |
| cpu_lvl_o | output | 16*NUM_CPU | Level vectors for the processors |

## Verification
A source or timer change is sampled at one clock edge and shows on `cpu_lvl_o` right after that edge. A register write affects the levels right after the edge that accepts it. Read data appears in the next cycle, together with `rsp_valid_o`. The bench drives every input on the falling edge and keeps a behavioural model that updates on each rising edge. It compares outputs against that model on the next falling edge, so every comparison lands in the cycle the result is due. Directed reads and level checks are timed the same way.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int SRC_W      = 32;
    localparam int LVL_W      = 16;
    localparam int DW         = 32;
    localparam int MASTER_BIT = 31;
    localparam int TOP_LVL    = 15;
    localparam int TMR_LVL    = 14;

    localparam logic [DW-1:0] MASK_RST   = 32'h0FA2_007F;
    localparam logic [DW-1:0] MASK_WRITE = ~MASK_RST;

    localparam logic [2:0] WO_PEND  = 3'd0;
    localparam logic [2:0] WO_MASK  = 3'd1;
    localparam logic [2:0] WO_UNMSK = 3'd2;
    localparam logic [2:0] WO_SETMK = 3'd3;
    localparam logic [2:0] WO_TGT   = 3'd4;

    typedef enum logic {BUS_IDLE, BUS_RESP} bus_state_e;

    function automatic logic [3:0] lvl_of(input int b);
        logic [3:0] r;
        r = 4'd0;
        if (b < 14) begin
            unique case (b % 7)
                0: r = 4'd2;
                1: r = 4'd3;
                2: r = 4'd5;
                3: r = 4'd7;
                4: r = 4'd9;
                5: r = 4'd11;
                default: r = 4'd13;
            endcase
        end else if (b < 16) begin
            r = 4'd12;
        end else if (b < 23) begin
            unique case (b)
                16: r = 4'd6;
                17: r = 4'd13;
                18: r = 4'd4;
                19: r = 4'd10;
                20: r = 4'd8;
                21: r = 4'd9;
                default: r = 4'd11;
            endcase
        end else if (b >= 27 && b <= 30) begin
            r = 4'd15;
        end
        return r;
    endfunction

    function automatic logic [SRC_W-1:0] routable();
        logic [SRC_W-1:0] m;
        m = '0;
        for (int b = 0; b < SRC_W; b++) m[b] = (lvl_of(b) != 4'd0);
        return m;
    endfunction

    localparam logic [SRC_W-1:0] ROUTE_MASK = routable();

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int TGT_W   = $clog2(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   src_i,
    input  logic [NUM_CPU-1:0] tmr_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic               req_write_i,
    input  logic [4:0]         req_addr_i,
    input  logic [DW-1:0]      req_wdata_i,
    output logic               rsp_valid_o,
    output logic [DW-1:0]      rsp_rdata_o,
    output logic [SRC_W-1:0]   pend_o,
    output logic [DW-1:0]      mask_o,
    output logic [TGT_W-1:0]   tgt_o,
    output logic [NUM_CPU-1:0] tmr_o
);

    bus_state_e state_q, state_d;
    logic [SRC_W-1:0]   pend_q;
    logic [DW-1:0]      mask_q;
    logic [TGT_W-1:0]   tgt_q;
    logic [NUM_CPU-1:0] tmr_q;
    logic [DW-1:0]      rdata_q;
    logic               take, aligned;
    logic [2:0]         word;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        req_ready_o = (state_q == BUS_IDLE);
        rsp_valid_o = (state_q == BUS_RESP);
    end

    assign take    = req_valid_i && req_ready_o;
    assign aligned = (req_addr_i[1:0] == 2'b00);
    assign word    = req_addr_i[4:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= MASK_RST;
            tgt_q   <= '0;
            tmr_q   <= '0;
            rdata_q <= '0;
        end else begin
            pend_q <= src_i & ROUTE_MASK;
            tmr_q  <= tmr_i;
            if (take) begin
                rdata_q <= '0;
                if (aligned && !req_write_i) begin
                    case (word)
                        WO_PEND: rdata_q <= pend_q & ~(32'h1 << MASTER_BIT);
                        WO_MASK: rdata_q <= mask_q & MASK_WRITE;
                        WO_TGT:  rdata_q <= {{(DW-TGT_W){1'b0}}, tgt_q};
                        default: rdata_q <= '0;
                    endcase
                end else if (aligned) begin
                    case (word)
                        WO_UNMSK: mask_q <= mask_q & ~(req_wdata_i & MASK_WRITE);
                        WO_SETMK: mask_q <= mask_q | (req_wdata_i & MASK_WRITE);
                        WO_TGT:   tgt_q  <= req_wdata_i[TGT_W-1:0];
                        default:  ;
                    endcase
                end
            end
        end
    end

    assign rsp_rdata_o = rdata_q;
    assign pend_o      = pend_q;
    assign mask_o      = mask_q;
    assign tgt_o       = tgt_q;
    assign tmr_o       = tmr_q;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> rsp_valid_o); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !req_ready_o); // R10
    AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mask_q & ~MASK_WRITE)); // R4
    AST_TGT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_write_i && req_addr_i == 5'h10) |=> tgt_q == $past(req_wdata_i[TGT_W-1:0])); // R6
    AST_PEND_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_write_i && req_addr_i == 5'h00) |=> !rsp_rdata_o[MASTER_BIT]); // R2

endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
    import irq_route_pkg::*;
(
    input  logic [SRC_W-1:0] pend_i,
    input  logic [DW-1:0]    mask_i,
    output logic [LVL_W-1:0] hw_lvl_o,
    output logic             top_o
);

    always_comb begin
        hw_lvl_o = '0;
        top_o    = 1'b0;
        for (int b = 0; b < SRC_W; b++) begin
            if (pend_i[b] && !mask_i[b]) hw_lvl_o[lvl_of(b)] = 1'b1;
            if (pend_i[b] && lvl_of(b) == 4'(TOP_LVL)) top_o = 1'b1;
        end
        hw_lvl_o[0] = 1'b0;
        if (mask_i[MASTER_BIT]) hw_lvl_o = '0;
    end

endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int TGT_W   = $clog2(NUM_CPU)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LVL_W-1:0]         hw_lvl_i,
    input  logic                     top_i,
    input  logic                     master_off_i,
    input  logic [TGT_W-1:0]         tgt_i,
    input  logic [NUM_CPU-1:0]       tmr_i,
    output logic [NUM_CPU*LVL_W-1:0] lvl_o
);

    for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
        logic [LVL_W-1:0] lvl;

        always_comb begin
            lvl = '0;
            if (tgt_i == TGT_W'(n)) lvl = hw_lvl_i;
            if (!master_off_i) begin
                lvl[TOP_LVL] = lvl[TOP_LVL] | top_i;
                lvl[TMR_LVL] = lvl[TMR_LVL] | tmr_i[n];
            end
        end

        assign lvl_o[n*LVL_W +: LVL_W] = lvl;

        AST_MASTER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            master_off_i |-> (lvl_o[n*LVL_W +: LVL_W] == '0)); // R7
        AST_ONLY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_i != TGT_W'(n)) |-> (lvl_o[n*LVL_W +: TMR_LVL] == '0)); // R6
        AST_TOP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            (!master_off_i && top_i) |-> lvl_o[n*LVL_W + TOP_LVL]); // R8
        AST_TMR_OWN: assert property (@(posedge clk) disable iff (!rst_n)
            !master_off_i |-> (lvl_o[n*LVL_W + TMR_LVL] == tmr_i[n])); // R9
        AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_o[n*LVL_W +: 2] == 2'b00); // R11
    end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [31:0]              src_i,
    input  logic [NUM_CPU-1:0]       tmr_i,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic                     req_write_i,
    input  logic [4:0]               req_addr_i,
    input  logic [31:0]              req_wdata_i,
    output logic                     rsp_valid_o,
    output logic [31:0]              rsp_rdata_o,
    output logic [NUM_CPU*16-1:0]    cpu_lvl_o
);

    localparam int TGT_W = $clog2(NUM_CPU);

    logic [SRC_W-1:0]   pend;
    logic [DW-1:0]      mask;
    logic [TGT_W-1:0]   tgt;
    logic [NUM_CPU-1:0] tmr;
    logic [LVL_W-1:0]   hw_lvl;
    logic               top;

    irq_route_regs #(.NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .tmr_i(tmr_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
        .rsp_rdata_o(rsp_rdata_o), .pend_o(pend), .mask_o(mask),
        .tgt_o(tgt), .tmr_o(tmr)
    );

    irq_route_map u_map (
        .pend_i(pend), .mask_i(mask), .hw_lvl_o(hw_lvl), .top_o(top)
    );

    irq_route_fanout #(.NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) u_fan (
        .clk(clk), .rst_n(rst_n), .hw_lvl_i(hw_lvl), .top_i(top),
        .master_off_i(mask[MASTER_BIT]), .tgt_i(tgt), .tmr_i(tmr),
        .lvl_o(cpu_lvl_o)
    );

endmodule

// File: tb/sim_irq_route_top.sv
`timescale 1ns/1ps
module sim_irq_route_top;
    localparam int NC = 16;

    logic clk = 0, rst_n = 0;
    logic [31:0] src = 0;
    logic [NC-1:0] tmr = 0;
    logic req_valid = 0, req_write = 0;
    logic [4:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NC*16-1:0] cpu_lvl;

    int checks = 0, fails = 0;
    bit run = 0;

    always #10 clk = ~clk;

    irq_route_top #(.NUM_CPU(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .tmr_i(tmr),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
        .rsp_rdata_o(rsp_rdata), .cpu_lvl_o(cpu_lvl)
    );

    int tbl [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                     6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

    logic [31:0] m_pend, m_mask, m_rdata;
    int m_tgt;
    logic [NC-1:0] m_tmr;
    bit m_busy;

    function automatic logic [15:0] model_lvl(int cpu);
        logic [15:0] v = 0;
        if (m_mask[31]) return 16'h0;
        for (int b = 0; b < 32; b++) begin
            if (m_pend[b] && tbl[b] != 0 && !m_mask[b] && cpu == m_tgt) v[tbl[b]] = 1;
            if (m_pend[b] && tbl[b] == 15) v[15] = 1;
        end
        if (m_tmr[cpu]) v[14] = 1;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_mask = 32'h0FA2007F; m_tgt = 0; m_tmr = 0; m_busy = 0; m_rdata = 0;
        end else begin
            if (req_valid && !m_busy) begin
                m_rdata = 0;
                if (req_addr[1:0] == 0) begin
                    if (!req_write) begin
                        if (req_addr == 5'h00) m_rdata = m_pend;
                        if (req_addr == 5'h04) m_rdata = m_mask & 32'hF05DFF80;
                        if (req_addr == 5'h10) m_rdata = 32'(m_tgt);
                    end else begin
                        if (req_addr == 5'h08) m_mask = m_mask & ~(req_wdata & 32'hF05DFF80);
                        if (req_addr == 5'h0C) m_mask = m_mask | (req_wdata & 32'hF05DFF80);
                        if (req_addr == 5'h10) m_tgt = int'(req_wdata % NC);
                    end
                end
                m_busy = 1;
            end else m_busy = 0;
            for (int b = 0; b < 32; b++) m_pend[b] = src[b] && tbl[b] != 0;
            m_tmr = tmr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            chk(req_ready == !m_busy, "R10 ready", 32'(req_ready), 32'(!m_busy));
            chk(rsp_valid == m_busy, "R10 rsp_valid", 32'(rsp_valid), 32'(m_busy));
            if (rsp_valid) chk(rsp_rdata == m_rdata, "R10 rdata", rsp_rdata, m_rdata);
            for (int c = 0; c < NC; c++)
                chk(cpu_lvl[c*16 +: 16] == model_lvl(c), "R3 model levels",
                    32'(cpu_lvl[c*16 +: 16]), 32'(model_lvl(c)));
        end
    end

    task automatic tick(); @(posedge clk); @(negedge clk); endtask

    task automatic bus(input logic wr, input logic [4:0] a, input logic [31:0] d, output logic [31:0] q);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        tick();
        req_valid = 0;
        q = rsp_rdata;
        tick();
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] q;
        bus(0, a, 0, q);
        chk(q == exp, tag, q, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(1, a, d, q);
    endtask

    task automatic lv(input int c, input logic [15:0] exp, input string tag);
        chk(cpu_lvl[c*16 +: 16] == exp, tag, 32'(cpu_lvl[c*16 +: 16]), 32'(exp));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected<20000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        run = 1;
        @(negedge clk);
        // R1 reset state
        for (int c = 0; c < NC; c++) lv(c, 16'h0, "R1 levels after reset");
        rd(5'h00, 0, "R1 pending after reset");
        rd(5'h04, 0, "R1 mask read after reset");
        rd(5'h10, 0, "R1 target after reset");
        // R3 table, R2 pending
        src = 32'h0000_0080; tick();
        lv(0, 16'h0004, "R3 bit7 to level 2");
        rd(5'h00, 32'h80, "R2 pending follows line");
        src = (1 << 16) | (1 << 22) | (1 << 14); tick();
        lv(0, 16'h1840, "R3 bits 14,16,22 to 12,6,11");
        src = 32'h8780_0000; tick();
        lv(0, 16'h0, "R2 level-0 bits ignored");
        rd(5'h00, 0, "R2 level-0 bits not pending");
        // R6 target
        wr(5'h10, 32'h25);
        rd(5'h10, 32'h5, "R6 target low bits");
        src = 1 << 8; tick();
        lv(5, 16'h0008, "R6 target gets level 3");
        lv(0, 16'h0, "R6 old target silent");
        // R5 mask keeps pending, R4 mask registers
        wr(5'h0C, 32'h100);
        lv(5, 16'h0, "R4 masked source blocked");
        rd(5'h00, 32'h100, "R5 pending kept under mask");
        rd(5'h04, 32'h100, "R4 mask readback");
        wr(5'h08, 32'h100);
        lv(5, 16'h0008, "R4 unmask restores level");
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h04, 0, "R4 locked bits hidden");
        src = 1 << 2; tick();
        lv(5, 16'h0, "R4 locked mask bit stays set");
        // R8 broadcast
        src = 1 << 28; tick();
        lv(0, 16'h8000, "R8 broadcast cpu0");
        lv(9, 16'h8000, "R8 broadcast cpu9");
        src = 1 << 27; tick();
        lv(3, 16'h8000, "R8 broadcast despite own mask");
        // R9 timer
        src = 0; tmr = 16'h0008; tick();
        lv(3, 16'h4000, "R9 timer own cpu");
        lv(4, 16'h0, "R9 timer not other cpu");
        // R7 master off
        src = (1 << 28) | (1 << 8); tmr = '1;
        wr(5'h0C, 32'h8000_0000);
        for (int c = 0; c < NC; c++) lv(c, 16'h0, "R7 master off silences");
        rd(5'h04, 32'h8000_0000, "R7 master bit readback");
        wr(5'h08, 32'h8000_0000);
        lv(5, 16'hC008, "R7 master cleared restores");
        // R10 misaligned and unused offsets
        wr(5'h11, 32'h3);
        rd(5'h10, 32'h5, "R10 misaligned write ignored");
        rd(5'h02, 0, "R10 misaligned read zero");
        rd(5'h14, 0, "R10 unused offset zero");
        // R11 full pattern
        src = '1; tmr = 0; tick();
        lv(5, 16'hBFFC, "R11 all sources layout");
        lv(6, 16'h8000, "R11 non-target layout");
        tick();
        run = 0;
        finish_run();
    end
endmodule